// File: doc/BRIEF.md
# SDRAM Read-Burst Output Datapath Model

This block is a synthesizable model of the device side of an SDRAM read data path. It is used to exercise and judge a memory controller. The block samples one command per clock edge: idle, read, write, precharge or burst stop. It also samples the byte-mask input on every edge. For each read it produces a burst of data beats on a DQ data output, paired with an output-enable that stands in for the tri-state drive. The beats start after the CAS latency and last for the selected burst length. Read data is generated arithmetically as the start column plus the beat index. Because no storage array is needed, a bench can tell from the value alone which beats were delivered.

The burst can be cut short by a precharge, a burst stop or a write. When a precharge or burst stop arrives, the beats already in flight still drain. When a write arrives, the output turns off at once. The mask input blanks read output two clocks after it is sampled, but it acts on a write in the same cycle. The block raises a one-cycle violation flag in two cases. The first is a write that cuts into read data when the mask was low on the clock before it. The second is a precharge or burst stop that interrupts a fixed-length read issued with auto precharge.

Top module: `sdr_read_model`

## Requirements
- R1: While reset is held and in the first cycle after it is released, dqOe, dqOut, wrAccept and protoErr are all 0.
- R2: cmd code 1 is a read. A read registered at edge e with colAddr c and casLat L (1 to 3) drives beat k as dqOe=1 and dqOut=c+k during the cycle after edge e+L-1+k. A read registered while a burst is running restarts the burst.
- R3: burstSel values 0, 1, 2 and 3, latched with the read, give bursts of 1, 2, 4 and 8 beats, after which dqOe returns to 0. burstSel values 4 to 7 give a full-page burst that continues until it is cut short.
- R4: cmd code 3 (precharge) or code 4 (burst stop) registered at edge t during a burst lets only the beats started at edges before t complete. The last beat is therefore valid L-1 cycles after t. Codes 0 and 5 to 7 have no effect.
- R5: dqm high at edge n forces dqOe to 0 in the cycle after edge n+1. The blanked beat still uses up its place in the burst.
- R6: cmd code 2 (write) registered at edge w forces dqOe to 0 from the cycle after edge w, and discards every read beat still pending.
- R7: A write counts as invalid if read data is pending at its edge and dqm was low at the edge before it. Read data is pending when a read beat was driven in the cycle before the write edge or is still to come. An invalid write raises protoErr for the cycle after the write edge, and wrAccept stays 0.
- R8: A valid write raises wrAccept for the cycle after its edge only if dqm is low at that same edge. dqm high at the write edge masks the beat.
- R9: A precharge or burst stop that cuts a fixed-length burst read with autoPre=1 raises protoErr for the cycle after its edge. The truncation still takes effect. A full-page read, or a burst that has already finished issuing, raises no flag.
- R10: Whenever dqOe is 0, dqOut is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| cmd | input | 3 | Command code: 0 idle, 1 read, 2 write, 3 precharge, 4 burst stop |
| colAddr | input | COLW | Start column, sampled with a read |
| autoPre | input | 1 | Auto-precharge option, sampled with a read |
| dqm | input | 1 | Byte mask: delayed blanking for reads, immediate masking for writes |
| burstSel | input | 3 | Burst length select, sampled with a read |
| casLat | input | CLW | CAS latency in cycles, 1 to MAX_CL |
| dqOut | output | DW | Read data beat |
| dqOe | output | 1 | Output enable for dqOut; low means high impedance |
| wrAccept | output | 1 | Pulse: a write data beat was taken unmasked |
| protoErr | output | 1 | Pulse: protocol violation detected |

## Verification
Two functions can land in the same cycle. One is a write that cuts short the read data still in flight. The other is the mask history that decides whether that write is legal. The bench provokes this by sweeping the write edge across every position of a four-beat burst at each CAS latency, both with the mask raised on the clock just before the write and with it left low. For each case it computes arithmetically whether any beat is still pending. It then expects high impedance from the write edge onward, together with either a violation pulse or an accepted-write pulse, but never both.

// File: rtl/sdr_read_pkg.sv
package sdr_read_pkg;

  typedef enum logic [2:0] {
    CMD_IDLE  = 3'd0,
    CMD_READ  = 3'd1,
    CMD_WRITE = 3'd2,
    CMD_PRE   = 3'd3,
    CMD_STOP  = 3'd4
  } cmdE;

  // strobes from control to datapath, valid in the cycle before an edge
  typedef struct packed {
    logic start;   // a new burst begins: latch the column
    logic issue;   // one beat enters the latency pipe
    logic flush;   // a write empties the pipe and the output
    logic blank;   // delayed mask: suppress the beat reaching the output
  } strobeT;

  function automatic cmdE decodeCmd(input logic [2:0] raw);
    case (raw)
      3'd1:    return CMD_READ;
      3'd2:    return CMD_WRITE;
      3'd3:    return CMD_PRE;
      3'd4:    return CMD_STOP;
      default: return CMD_IDLE;
    endcase
  endfunction

endpackage

// File: rtl/sdr_read_ctrl.sv
module sdr_read_ctrl
  import sdr_read_pkg::*;
#(
  parameter int BEATW = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [2:0]       cmd,
  input  logic             autoPre,
  input  logic             dqm,
  input  logic [2:0]       burstSel,
  input  logic             dpBusy,
  output strobeT           strobes,
  output logic [BEATW-1:0] beatIdx,
  output logic             wrAccept,
  output logic             protoErr
);

  cmdE              cmdDec;
  logic             isRead, isWrite, isTrunc;
  logic             activeQ, fullQ, autoQ, dqmQ;
  logic [BEATW-1:0] beatQ, lastQ;
  logic [BEATW-1:0] lastN;
  logic             fullN;
  logic             wrBad, apViol;
  logic             wrAcceptQ, errQ;

  always_comb begin
    cmdDec  = decodeCmd(cmd);
    isRead  = (cmdDec == CMD_READ);
    isWrite = (cmdDec == CMD_WRITE);
    isTrunc = (cmdDec == CMD_PRE) || (cmdDec == CMD_STOP);
  end

  // burst length decode, applied when a read is taken
  always_comb begin
    fullN = burstSel[2];
    case (burstSel)
      3'd0:    lastN = BEATW'(0);
      3'd1:    lastN = BEATW'(1);
      3'd2:    lastN = BEATW'(3);
      3'd3:    lastN = BEATW'(7);
      default: lastN = '1;
    endcase
  end

  always_comb begin
    strobes.start = isRead;
    strobes.issue = isRead || (activeQ && !isWrite && !isTrunc);
    strobes.flush = isWrite;
    strobes.blank = dqmQ;
    beatIdx       = isRead ? '0 : beatQ;
    wrBad         = isWrite && (activeQ || dpBusy) && !dqmQ;
    apViol        = isTrunc && activeQ && autoQ && !fullQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeQ   <= 1'b0;
      fullQ     <= 1'b0;
      autoQ     <= 1'b0;
      beatQ     <= '0;
      lastQ     <= '0;
      dqmQ      <= 1'b0;
      wrAcceptQ <= 1'b0;
      errQ      <= 1'b0;
    end else begin
      dqmQ      <= dqm;
      wrAcceptQ <= isWrite && !dqm && !wrBad;
      errQ      <= wrBad || apViol;
      if (isRead) begin
        activeQ <= fullN || (lastN != '0);
        fullQ   <= fullN;
        autoQ   <= autoPre;
        lastQ   <= lastN;
        beatQ   <= BEATW'(1);
      end else if (isWrite || isTrunc) begin
        activeQ <= 1'b0;
      end else if (activeQ) begin
        beatQ <= beatQ + BEATW'(1);
        if (!fullQ && (beatQ == lastQ)) activeQ <= 1'b0;
      end
    end
  end

  assign wrAccept = wrAcceptQ;
  assign protoErr = errQ;

  // a cut command ends issuing at once
  assert_trunc_stops_R4: assert property (@(posedge clk) disable iff (!rstN)
    isTrunc |=> !activeQ);

  // a fixed-length burst never runs past its last beat
  assert_beat_bound_R3: assert property (@(posedge clk) disable iff (!rstN)
    (activeQ && !fullQ) |-> (beatQ <= lastQ));

  // a write is never both accepted and flagged
  assert_wr_excl_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(wrAccept && protoErr));

endmodule

// File: rtl/sdr_read_dpath.sv
module sdr_read_dpath
  import sdr_read_pkg::*;
#(
  parameter int DW     = 16,
  parameter int COLW   = 9,
  parameter int BEATW  = 9,
  parameter int MAX_CL = 3,
  parameter int CLW    = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobeT           strobes,
  input  logic [BEATW-1:0] beatIdx,
  input  logic [COLW-1:0]  colAddr,
  input  logic [CLW-1:0]   casLat,
  output logic [DW-1:0]    dqOut,
  output logic             dqOe,
  output logic             busy
);

  logic [COLW-1:0] colQ;
  logic [COLW-1:0] curCol;
  logic [DW-1:0]   issueData;
  logic [CLW-1:0]  clIdx;
  logic            tapV [MAX_CL];
  logic [DW-1:0]   tapD [MAX_CL];
  logic            rawQ, oeQ;
  logic [DW-1:0]   dQ;

  always_comb begin
    curCol    = strobes.start ? colAddr : colQ;
    issueData = DW'(curCol) + DW'(beatIdx);
    if (casLat == '0)                   clIdx = '0;
    else if (casLat > CLW'(MAX_CL))     clIdx = CLW'(MAX_CL - 1);
    else                                clIdx = casLat - CLW'(1);
  end

  assign tapV[0] = strobes.issue;
  assign tapD[0] = issueData;

  // latency delay line: stage g holds a beat started g edges ago
  for (genvar g = 1; g < MAX_CL; g++) begin : gStage
    logic          vQ;
    logic [DW-1:0] stD;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        vQ  <= 1'b0;
        stD <= '0;
      end else if (strobes.flush) begin
        vQ  <= 1'b0;
        stD <= '0;
      end else begin
        vQ  <= tapV[g-1];
        stD <= tapD[g-1];
      end
    end
    assign tapV[g] = vQ;
    assign tapD[g] = stD;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) colQ <= '0;
    else if (strobes.start) colQ <= colAddr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rawQ <= 1'b0;
      oeQ  <= 1'b0;
      dQ   <= '0;
    end else begin
      rawQ <= !strobes.flush && tapV[clIdx];
      oeQ  <= !strobes.flush && tapV[clIdx] && !strobes.blank;
      dQ   <= (!strobes.flush && tapV[clIdx] && !strobes.blank) ? tapD[clIdx] : '0;
    end
  end

  // any beat on the bus or still inside the selected latency window
  always_comb begin
    busy = rawQ;
    for (int i = 1; i < MAX_CL; i++) begin
      if (i <= int'(clIdx)) busy = busy | tapV[i];
    end
  end

  assign dqOut = dQ;
  assign dqOe  = oeQ;

  assert_flush_hiz_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.flush |=> (!dqOe && !busy));

  assert_blank_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.blank |=> !dqOe);

  assert_idle_zero_R10: assert property (@(posedge clk) disable iff (!rstN)
    !dqOe |-> (dqOut == '0));

endmodule

// File: rtl/sdr_read_model.sv
module sdr_read_model
  import sdr_read_pkg::*;
#(
  parameter int  DW     = 16,
  parameter int  COLW   = 9,
  parameter int  MAX_CL = 3,
  localparam int CLW    = $clog2(MAX_CL + 1),
  localparam int BEATW  = COLW
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [2:0]      cmd,
  input  logic [COLW-1:0] colAddr,
  input  logic            autoPre,
  input  logic            dqm,
  input  logic [2:0]      burstSel,
  input  logic [CLW-1:0]  casLat,
  output logic [DW-1:0]   dqOut,
  output logic            dqOe,
  output logic            wrAccept,
  output logic            protoErr
);

  strobeT           strobes;
  logic [BEATW-1:0] beatIdx;
  logic             dpBusy;

  sdr_read_ctrl #(.BEATW(BEATW)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .cmd      (cmd),
    .autoPre  (autoPre),
    .dqm      (dqm),
    .burstSel (burstSel),
    .dpBusy   (dpBusy),
    .strobes  (strobes),
    .beatIdx  (beatIdx),
    .wrAccept (wrAccept),
    .protoErr (protoErr)
  );

  sdr_read_dpath #(
    .DW(DW), .COLW(COLW), .BEATW(BEATW), .MAX_CL(MAX_CL), .CLW(CLW)
  ) uDpath (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .beatIdx (beatIdx),
    .colAddr (colAddr),
    .casLat  (casLat),
    .dqOut   (dqOut),
    .dqOe    (dqOe),
    .busy    (dpBusy)
  );

  assert_write_hiz_R6: assert property (@(posedge clk) disable iff (!rstN)
    (cmd == 3'd2) |=> !dqOe);

  assert_dqm_latency_R5: assert property (@(posedge clk) disable iff (!rstN)
    dqm |-> ##2 !dqOe);

endmodule

// File: tb/tb_sdr_read_model.sv
`timescale 1ns/1ps
module tb_sdr_read_model;

  localparam int DW = 16;
  localparam int COLW = 9;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [2:0]      cmd = 3'd0;
  logic [COLW-1:0] colAddr = '0;
  logic            autoPre = 1'b0;
  logic            dqm = 1'b0;
  logic [2:0]      burstSel = 3'd0;
  logic [1:0]      casLat = 2'd1;
  logic [DW-1:0]   dqOut;
  logic            dqOe;
  logic            wrAccept;
  logic            protoErr;

  int nTests = 0;
  int nFail  = 0;
  bit doneFlag = 1'b0;

  always #2.5 clk = ~clk;

  sdr_read_model #(.DW(DW), .COLW(COLW), .MAX_CL(3)) dut (
    .clk(clk), .rstN(rstN), .cmd(cmd), .colAddr(colAddr), .autoPre(autoPre),
    .dqm(dqm), .burstSel(burstSel), .casLat(casLat), .dqOut(dqOut),
    .dqOe(dqOe), .wrAccept(wrAccept), .protoErr(protoErr)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", req, what, act, exp, $time);
    end
  endtask

  // one read at edge 0, optional cutting command at edge tAt, dqm per edge from mask
  // tKind: 0 none, 2 write, 3 precharge, 4 burst stop
  task automatic runSeq(input int cl, input int bsel, input int col, input bit ap,
                        input int tKind, input int tAt, input logic [31:0] mask,
                        input int n);
    int lenB  = (bsel < 4) ? (1 << bsel) : 100000;
    int tStop = (tKind != 0) ? tAt : 100000;
    int nb    = (lenB < tStop) ? lenB : tStop;
    bit wrErr = (tKind == 2) && (tAt >= 1) && (tAt <= cl - 1 + nb) && !mask[tAt-1];
    casLat   = 2'(cl);
    burstSel = 3'(bsel);
    @(negedge clk);
    cmd = 3'd1; colAddr = COLW'(col); autoPre = ap; dqm = mask[0];
    for (int i = 0; i < n; i++) begin
      int  k;
      bit  expOe, expErr, expWr;
      int  expD;
      @(posedge clk);
      @(negedge clk);
      k = i - (cl - 1);
      expOe = (k >= 0) && (k < nb) && !((tKind == 2) && (i >= tAt)) &&
              !((i >= 1) && mask[i-1]);
      expD  = expOe ? (col + k) : 0;
      expErr = ((tKind == 3 || tKind == 4) && (i == tAt) && ap && (bsel < 4) &&
                (tAt >= 1) && (tAt < lenB)) ||
               ((tKind == 2) && (i == tAt) && wrErr);
      expWr  = (tKind == 2) && (i == tAt) && !mask[tAt] && !wrErr;
      // R2 R3 R4 R5 R6: enable per cycle; R10: data zero when disabled
      chk(dqOe == expOe, "R2/R3/R4/R5/R6", $sformatf("dqOe cl=%0d bsel=%0d t%0d@%0d j=%0d",
          cl, bsel, tKind, tAt, i), int'(dqOe), int'(expOe));
      chk(int'(dqOut) == expD, expOe ? "R2" : "R10",
          $sformatf("dqOut cl=%0d bsel=%0d j=%0d", cl, bsel, i), int'(dqOut), expD);
      chk(protoErr == expErr, (tKind == 2) ? "R7" : "R9",
          $sformatf("protoErr cl=%0d t%0d@%0d j=%0d", cl, tKind, tAt, i),
          int'(protoErr), int'(expErr));
      chk(wrAccept == expWr, "R8", $sformatf("wrAccept cl=%0d j=%0d", cl, i),
          int'(wrAccept), int'(expWr));
      if (i + 1 < n) begin
        cmd = (tKind != 0 && (i + 1) == tAt) ? 3'(tKind) : 3'd0;
        dqm = mask[i+1];
      end
    end
    cmd = 3'd0; dqm = 1'b0; autoPre = 1'b0;
    repeat (6) @(posedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!doneFlag) begin
      nTests++;
      nFail++;
      $display("FAIL watchdog: actual 0 expected 1 (run finished)");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk(dqOe == 1'b0 && dqOut == '0, "R1", "outputs in reset", int'(dqOe), 0);
    chk(wrAccept == 1'b0 && protoErr == 1'b0, "R1", "pulses in reset", int'(protoErr), 0);
    rstN = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk(dqOe == 1'b0 && dqOut == '0, "R1", "outputs after reset", int'(dqOut), 0);

    for (int cl = 1; cl <= 3; cl++) begin
      // R2 R3: full bursts of each fixed length
      for (int b = 0; b < 4; b++) runSeq(cl, b, 16 * b + 100 * cl, 0, 0, 0, 32'h0, 20);
      // R3 R4: full page stopped by burst stop
      runSeq(cl, 7, 40, 0, 4, 13, 32'h0, 24);
      // R4: cut at every beat of an eight-beat burst
      for (int t = 1; t <= 8; t++) runSeq(cl, 3, 200, 0, (t % 2 == 1) ? 3 : 4, t, 32'h0, 20);
      // R5: mask patterns
      runSeq(cl, 3, 50, 0, 0, 0, 32'h0000_0052, 20);
      runSeq(cl, 3, 60, 0, 0, 0, 32'h0000_0007, 20);
      // R6 R7 R8: write at each edge, mask set before it and not
      for (int w = 1; w <= 7; w++) begin
        runSeq(cl, 2, 300, 0, 2, w, 32'h1 << (w - 1), 16);
        runSeq(cl, 2, 300, 0, 2, w, 32'h0, 16);
        runSeq(cl, 2, 300, 0, 2, w, (32'h1 << (w - 1)) | (32'h1 << w), 16);
      end
      // R9: auto precharge cuts
      runSeq(cl, 2, 70, 1, 3, 2, 32'h0, 16);
      runSeq(cl, 2, 70, 1, 4, 3, 32'h0, 16);
      runSeq(cl, 2, 70, 1, 3, 5, 32'h0, 16);
      runSeq(cl, 7, 70, 1, 3, 6, 32'h0, 20);
      runSeq(cl, 3, 80, 0, 4, 2, 32'h0, 16);
    end

    // R8: idle writes, masked then unmasked
    @(negedge clk);
    cmd = 3'd2; dqm = 1'b1;
    @(posedge clk); @(negedge clk);
    chk(wrAccept == 1'b0, "R8", "masked write", int'(wrAccept), 0);
    chk(protoErr == 1'b0, "R7", "idle write flag", int'(protoErr), 0);
    cmd = 3'd2; dqm = 1'b0;
    @(posedge clk); @(negedge clk);
    chk(wrAccept == 1'b1, "R8", "unmasked write", int'(wrAccept), 1);
    cmd = 3'd5;
    @(posedge clk); @(negedge clk);
    chk(dqOe == 1'b0 && wrAccept == 1'b0, "R4", "unused code idle", int'(dqOe), 0);
    cmd = 3'd0;
    repeat (2) @(posedge clk);

    doneFlag = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule